// File: doc/BRIEF.md
# Clock-Control Register Bank

This block is the software-visible register front end of a clock-generation unit. It keeps the control, divider, regulator-control and lock-count settings, shows a live status word, and returns a chip identifier. All six entries sit behind one simple synchronous bus. A request carries an address, a write enable, an access size and write data. The response arrives on the next clock edge as registered read data and a one-cycle error flag.

Each register has its own legal access widths, and the size check is made before the address is decoded. Writes that fail a check change nothing. The status word and the chip identifier are read-only, so writes to them of a legal width are accepted and silently dropped. The control and divider values drive output ports straight to the clock logic. The status bits and the identifier come in from outside the bank.

Top module: `clkctl_regbank`

## Requirements
- R1: Registers sit at byte offset 4*index: control index 0, divider 1, regulator control 2, status 3, lock count 4, chip identifier 5.
- R2: The size encoding is 0 = 8-bit, 1 = 16-bit, 2 = 32-bit and 3 = reserved. Any access of size 0 or 3 gets an error, whatever its address, and leaves all state unchanged.
- R3: Control, divider, regulator control and lock count accept 16-bit reads and writes. A 32-bit access to any of them gets an error, leaves the register unchanged and reads as zero.
- R4: Status is read-only. A 16-bit write gets no error and has no effect, and a 32-bit access gets an error. A read returns `stat_in` as sampled on the previous clock edge.
- R5: A 32-bit read of the chip identifier returns all of `chip_id`, and a 16-bit read returns its low 16 bits. Writes of either legal size get no error and have no effect.
- R6: An address that is not a multiple of 4, or whose index is 6 or more, gets an error, changes no state and reads as zero.
- R7: A 16-bit read returns the value zero-extended in bits 15:0. A write stores only `bus_wdata[15:0]`.
- R8: The response comes one cycle after the request. `bus_err` is high for exactly that one cycle. `bus_rdata` is zero for writes, for failed accesses and in cycles that follow no request.
- R9: Synchronous active-high reset sets control 0xA800, divider 0x0004, regulator control 0x40FB and lock count 0x0300. `ctl_out` and `div_out` always show the current control and divider values.
- R10: Reset sets the stored status to 0x00A2. A status read issued in the first cycle after reset returns 0x00A2 whatever `stat_in` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Access request for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address within the bank |
| bus_size | input | 2 | Access size code |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| bus_err | output | 1 | Registered error pulse |
| chip_id | input | ID_W | Chip identifier value |
| stat_in | input | 16 | Live status bits |
| ctl_out | output | 16 | Current control register |
| div_out | output | 16 | Current divider register |

## Verification
The status register takes in `stat_in` on every edge, and a status read captures that register on the same edge, so the two events overlap. The bench sets up this overlap in two ways. First, it releases reset and issues a status read in the same cycle while `stat_in` holds a different value; the read must return the stored reset value 0x00A2. Second, it changes `stat_in` a whole cycle before a later read; that read must return the new value.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_RSVD = 2'd3
   } acc_size_e;

   localparam int REG_W    = 16;
   localparam int NUM_REGS = 6;
   localparam int NUM_RW   = 4;

   localparam int IDX_CTL  = 0;
   localparam int IDX_DIV  = 1;
   localparam int IDX_VREG = 2;
   localparam int IDX_STAT = 3;
   localparam int IDX_LOCK = 4;
   localparam int IDX_ID   = 5;

   localparam logic [REG_W-1:0] STAT_RST = 16'h00A2;

   // writable slot number -> register index (status at 3 is skipped)
   function automatic int rw_slot_index(input int slot);
      return (slot < IDX_STAT) ? slot : slot + 1;
   endfunction

   function automatic logic [REG_W-1:0] rw_reset_value(input int slot);
      logic [REG_W-1:0] v;
      case (slot)
         0:       v = 16'hA800;
         1:       v = 16'h0004;
         2:       v = 16'h40FB;
         default: v = 16'h0300;
      endcase
      return v;
   endfunction

endpackage

// File: rtl/clkctl_acc_dec.sv
module clkctl_acc_dec
   import clkctl_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int IDX_W  = 3
) (
   input  logic                  req,
   input  logic                  we,
   input  logic [ADDR_W-1:0]     addr,
   input  logic [1:0]            size,
   output logic                  acc_ok,
   output logic                  acc_err,
   output logic [IDX_W-1:0]      idx,
   output logic [NUM_RW-1:0]     rw_wen
);
   localparam int WORD_W = ADDR_W - 2;

   logic [WORD_W-1:0] word;
   logic              size_ok;
   logic              addr_ok;
   logic              width_ok;

   assign word = addr[ADDR_W-1:2];
   assign idx  = word[IDX_W-1:0];

   // size check first: it outranks the address decode
   assign size_ok  = (size == SZ_HALF) || (size == SZ_WORD);
   assign addr_ok  = (addr[1:0] == 2'b00) && (word < WORD_W'(NUM_REGS));
   assign width_ok = (size == SZ_HALF) || (word == WORD_W'(IDX_ID));

   assign acc_ok  = req && size_ok && addr_ok && width_ok;
   assign acc_err = req && !(size_ok && addr_ok && width_ok);

   for (genvar s = 0; s < NUM_RW; s++) begin : g_wen
      localparam int RI = rw_slot_index(s);
      assign rw_wen[s] = acc_ok && we && (word == WORD_W'(RI));
   end

endmodule

// File: rtl/clkctl_reg_store.sv
module clkctl_reg_store
   import clkctl_pkg::*;
(
   input  logic                              clk,
   input  logic                              rst,
   input  logic [NUM_RW-1:0]                 wen,
   input  logic [REG_W-1:0]                  wdata,
   input  logic [REG_W-1:0]                  stat_in,
   output logic [NUM_RW-1:0][REG_W-1:0]      rw_q,
   output logic [REG_W-1:0]                  stat_q
);

   for (genvar s = 0; s < NUM_RW; s++) begin : g_reg
      always_ff @(posedge clk) begin
         if (rst)         rw_q[s] <= rw_reset_value(s);
         else if (wen[s]) rw_q[s] <= wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) stat_q <= STAT_RST;
      else     stat_q <= stat_in;
   end

endmodule

// File: rtl/clkctl_rd_mux.sv
module clkctl_rd_mux
   import clkctl_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ID_W   = 32,
   parameter int IDX_W  = 3
) (
   input  logic [IDX_W-1:0]              idx,
   input  logic [1:0]                    size,
   input  logic [NUM_RW-1:0][REG_W-1:0]  rw_q,
   input  logic [REG_W-1:0]              stat_q,
   input  logic [ID_W-1:0]               chip_id,
   output logic [DATA_W-1:0]             rd_val
);
   logic [REG_W-1:0] id_low;

   if (ID_W > REG_W) begin : g_id_wide
      assign id_low = chip_id[REG_W-1:0];
   end else begin : g_id_narrow
      assign id_low = chip_id;
   end

   always_comb begin
      rd_val = '0;
      if (idx == IDX_W'(IDX_STAT)) begin
         rd_val[REG_W-1:0] = stat_q;
      end else if (idx == IDX_W'(IDX_ID)) begin
         if (size == SZ_WORD) rd_val[ID_W-1:0]  = chip_id;
         else                 rd_val[REG_W-1:0] = id_low;
      end else begin
         for (int s = 0; s < NUM_RW; s++) begin
            if (idx == IDX_W'(rw_slot_index(s))) rd_val[REG_W-1:0] = rw_q[s];
         end
      end
   end

endmodule

// File: rtl/clkctl_regbank.sv
module clkctl_regbank
   import clkctl_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32,
   parameter int ID_W   = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              bus_req,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [1:0]        bus_size,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              bus_err,
   input  logic [ID_W-1:0]   chip_id,
   input  logic [REG_W-1:0]  stat_in,
   output logic [REG_W-1:0]  ctl_out,
   output logic [REG_W-1:0]  div_out
);
   localparam int IDX_W = $clog2(NUM_REGS);

   if (ADDR_W < IDX_W + 2) begin : g_chk_addr
      $error("ADDR_W too small for the register index");
   end
   if (DATA_W < ID_W || ID_W < REG_W) begin : g_chk_width
      $error("need REG_W <= ID_W <= DATA_W");
   end

   logic                          acc_ok;
   logic                          acc_err;
   logic [IDX_W-1:0]              idx;
   logic [NUM_RW-1:0]             rw_wen;
   logic [NUM_RW-1:0][REG_W-1:0]  rw_q;
   logic [REG_W-1:0]              stat_q;
   logic [DATA_W-1:0]             rd_val;
   logic                          unused_wdata_hi;

   assign unused_wdata_hi = ^bus_wdata[DATA_W-1:REG_W];

   clkctl_acc_dec #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dec (
      .req     (bus_req),
      .we      (bus_we),
      .addr    (bus_addr),
      .size    (bus_size),
      .acc_ok  (acc_ok),
      .acc_err (acc_err),
      .idx     (idx),
      .rw_wen  (rw_wen)
   );

   clkctl_reg_store u_store (
      .clk     (clk),
      .rst     (rst),
      .wen     (rw_wen),
      .wdata   (bus_wdata[REG_W-1:0]),
      .stat_in (stat_in),
      .rw_q    (rw_q),
      .stat_q  (stat_q)
   );

   clkctl_rd_mux #(.DATA_W(DATA_W), .ID_W(ID_W), .IDX_W(IDX_W)) u_rmux (
      .idx     (idx),
      .size    (bus_size),
      .rw_q    (rw_q),
      .stat_q  (stat_q),
      .chip_id (chip_id),
      .rd_val  (rd_val)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         bus_rdata <= '0;
         bus_err   <= 1'b0;
      end else begin
         bus_err   <= acc_err;
         bus_rdata <= (acc_ok && !bus_we) ? rd_val : '0;
      end
   end

   assign ctl_out = rw_q[0];
   assign div_out = rw_q[1];

endmodule

// File: rtl/clkctl_regbank_chk.sv
module clkctl_regbank_chk
   import clkctl_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32,
   parameter int ID_W   = 32
) (
   input logic              clk,
   input logic              rst,
   input logic              bus_req,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [1:0]        bus_size,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              bus_err,
   input logic [ID_W-1:0]   chip_id,
   input logic [REG_W-1:0]  stat_in,
   input logic [REG_W-1:0]  ctl_out,
   input logic [REG_W-1:0]  div_out
);
   localparam int WW = ADDR_W - 2;

   logic          rst_d = 1'b0;
   logic [WW-1:0] w_idx;
   logic          size_bad;
   logic          addr_bad;
   logic          unused_chk;

   always_ff @(posedge clk) rst_d <= rst;

   assign w_idx      = bus_addr[ADDR_W-1:2];
   assign size_bad   = (bus_size != SZ_HALF) && (bus_size != SZ_WORD);
   assign addr_bad   = (bus_addr[1:0] != 2'b00) || (w_idx >= WW'(NUM_REGS));
   assign unused_chk = ^{bus_wdata, chip_id, stat_in};

   a_r2_width_err: assert property (@(posedge clk) disable iff (rst)
      bus_req && size_bad |=> bus_err);

   a_r3_wide_rejected: assert property (@(posedge clk) disable iff (rst)
      bus_req && bus_size == SZ_WORD && !addr_bad && w_idx != WW'(IDX_ID) |=> bus_err);

   a_r5_id_write_ok: assert property (@(posedge clk) disable iff (rst)
      bus_req && bus_we && !size_bad && !addr_bad && w_idx == WW'(IDX_ID) |=> !bus_err);

   a_r6_bad_write_holds: assert property (@(posedge clk) disable iff (rst)
      bus_req && bus_we && (size_bad || addr_bad) |=> $stable(ctl_out) && $stable(div_out));

   a_r6_err_reads_zero: assert property (@(posedge clk) disable iff (rst)
      bus_err |-> bus_rdata == '0);

   a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
      !bus_req |=> !bus_err && bus_rdata == '0);

   a_r9_reset_vals: assert property (@(posedge clk)
      rst_d |-> ctl_out == 16'hA800 && div_out == 16'h0004);

endmodule

bind clkctl_regbank clkctl_regbank_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W)
) u_chk (.*);

// File: tb/sim_clkctl_regbank.sv
module sim_clkctl_regbank;
   import clkctl_pkg::*;

   localparam int AW = 8;
   localparam int DW = 32;
   localparam int IW = 32;
   localparam logic [31:0] ID_VAL = 32'h27A5_10CB;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          req = 1'b0;
   logic          we = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [1:0]    size = SZ_HALF;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          err;
   logic [IW-1:0] chip_id = ID_VAL;
   logic [15:0]   stat_in = 16'h1234;
   logic [15:0]   ctl_out;
   logic [15:0]   div_out;

   int total = 0;
   int bad = 0;

   always #10 clk = ~clk;

   clkctl_regbank #(.ADDR_W(AW), .DATA_W(DW), .ID_W(IW)) u0 (
      .clk(clk), .rst(rst), .bus_req(req), .bus_we(we), .bus_addr(addr),
      .bus_size(size), .bus_wdata(wdata), .bus_rdata(rdata), .bus_err(err),
      .chip_id(chip_id), .stat_in(stat_in), .ctl_out(ctl_out), .div_out(div_out)
   );

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   task automatic access(input logic w, input logic [AW-1:0] a, input logic [1:0] s,
                         input logic [31:0] d, output logic [31:0] rd, output logic e);
      @(negedge clk);
      req = 1'b1; we = w; addr = a; size = s; wdata = d;
      @(negedge clk);
      rd = rdata; e = err;
      req = 1'b0; we = 1'b0;
   endtask

   task automatic t_reset;
      logic [31:0] rd; logic e;
      rst = 1'b1;
      repeat (3) @(negedge clk);
      check("R9 ctl_out reset", {16'h0, ctl_out}, 32'h0000_A800);
      check("R9 div_out reset", {16'h0, div_out}, 32'h0000_0004);
      rst = 1'b0; req = 1'b1; we = 1'b0; addr = 8'h0C; size = SZ_HALF;
      @(negedge clk);
      check("R10 status first read", rdata, 32'h0000_00A2);
      check("R10 status err", {31'h0, err}, 32'h0);
      req = 1'b0;
      access(1'b0, 8'h08, SZ_HALF, 0, rd, e);
      check("R9 vreg reset", rd, 32'h0000_40FB);
      access(1'b0, 8'h10, SZ_HALF, 0, rd, e);
      check("R9 lock reset", rd, 32'h0000_0300);
      access(1'b0, 8'h0C, SZ_HALF, 0, rd, e);
      check("R4 status follows input", rd, 32'h0000_1234);
   endtask

   task automatic t_readwrite;
      logic [31:0] rd; logic e;
      access(1'b1, 8'h00, SZ_HALF, 32'hBEEF_1357, rd, e);
      check("R8 write rdata zero", rd, 32'h0);
      check("R3 half write ok", {31'h0, e}, 32'h0);
      check("R7 ctl_out low half", {16'h0, ctl_out}, 32'h0000_1357);
      access(1'b1, 8'h04, SZ_HALF, 32'hFFFF_0009, rd, e);
      access(1'b1, 8'h08, SZ_HALF, 32'h0000_5A5A, rd, e);
      access(1'b1, 8'h10, SZ_HALF, 32'h1111_0123, rd, e);
      check("R9 div_out follows", {16'h0, div_out}, 32'h0000_0009);
      access(1'b0, 8'h00, SZ_HALF, 0, rd, e);
      check("R1 R7 ctl readback", rd, 32'h0000_1357);
      access(1'b0, 8'h04, SZ_HALF, 0, rd, e);
      check("R1 div readback", rd, 32'h0000_0009);
      access(1'b0, 8'h08, SZ_HALF, 0, rd, e);
      check("R1 vreg readback", rd, 32'h0000_5A5A);
      access(1'b0, 8'h10, SZ_HALF, 0, rd, e);
      check("R1 lock readback", rd, 32'h0000_0123);
   endtask

   task automatic t_width;
      logic [31:0] rd; logic e;
      access(1'b0, 8'h00, SZ_BYTE, 0, rd, e);
      check("R2 byte read err", {31'h0, e}, 32'h1);
      check("R2 byte read zero", rd, 32'h0);
      access(1'b1, 8'h00, SZ_BYTE, 32'hFFFF, rd, e);
      check("R2 byte write err", {31'h0, e}, 32'h1);
      check("R2 byte write ignored", {16'h0, ctl_out}, 32'h0000_1357);
      access(1'b0, 8'h40, SZ_RSVD, 0, rd, e);
      check("R2 reserved size unmapped err", {31'h0, e}, 32'h1);
      access(1'b1, 8'h04, SZ_WORD, 32'h77, rd, e);
      check("R3 word write err", {31'h0, e}, 32'h1);
      check("R3 word write ignored", {16'h0, div_out}, 32'h0000_0009);
      access(1'b0, 8'h10, SZ_WORD, 0, rd, e);
      check("R3 word read err", {31'h0, e}, 32'h1);
      check("R3 word read zero", rd, 32'h0);
   endtask

   task automatic t_status;
      logic [31:0] rd; logic e;
      access(1'b1, 8'h0C, SZ_HALF, 32'hFFFF, rd, e);
      check("R4 status half write ok", {31'h0, e}, 32'h0);
      stat_in = 16'h0055;
      access(1'b0, 8'h0C, SZ_HALF, 0, rd, e);
      check("R4 status reads input", rd, 32'h0000_0055);
      access(1'b1, 8'h0C, SZ_WORD, 32'hFFFF, rd, e);
      check("R4 status word write err", {31'h0, e}, 32'h1);
   endtask

   task automatic t_chipid;
      logic [31:0] rd; logic e;
      access(1'b0, 8'h14, SZ_WORD, 0, rd, e);
      check("R5 id word read", rd, ID_VAL);
      access(1'b0, 8'h14, SZ_HALF, 0, rd, e);
      check("R5 id half read", rd, {16'h0, ID_VAL[15:0]});
      access(1'b1, 8'h14, SZ_HALF, 32'h0, rd, e);
      check("R5 id half write ok", {31'h0, e}, 32'h0);
      access(1'b1, 8'h14, SZ_WORD, 32'h0, rd, e);
      check("R5 id word write ok", {31'h0, e}, 32'h0);
      access(1'b0, 8'h14, SZ_WORD, 0, rd, e);
      check("R5 id unchanged", rd, ID_VAL);
   endtask

   task automatic t_unmapped;
      logic [31:0] rd; logic e;
      access(1'b0, 8'h18, SZ_HALF, 0, rd, e);
      check("R6 index 6 err", {31'h0, e}, 32'h1);
      check("R6 index 6 zero", rd, 32'h0);
      access(1'b1, 8'h01, SZ_HALF, 32'hAAAA, rd, e);
      check("R6 unaligned err", {31'h0, e}, 32'h1);
      check("R6 unaligned ignored", {16'h0, ctl_out}, 32'h0000_1357);
      access(1'b1, 8'h3C, SZ_HALF, 32'hAAAA, rd, e);
      check("R6 high index err", {31'h0, e}, 32'h1);
      access(1'b0, 8'h00, SZ_HALF, 0, rd, e);
      check("R6 ctl untouched", rd, 32'h0000_1357);
   endtask

   task automatic t_pulse;
      logic [31:0] rd; logic e;
      access(1'b0, 8'h00, SZ_BYTE, 0, rd, e);
      check("R8 err pulse high", {31'h0, e}, 32'h1);
      @(negedge clk);
      check("R8 err pulse one cycle", {31'h0, err}, 32'h0);
      check("R8 idle rdata zero", rdata, 32'h0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      t_reset();
      t_readwrite();
      t_width();
      t_status();
      t_chipid();
      t_unmapped();
      t_pulse();
      repeat (2) @(negedge clk);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule